// File: doc/BRIEF.md
# Virtual Address Segment Guard

This block sits in front of the address translation buffer of a 32-bit core. Every request carries a virtual address, an access width, an access kind (instruction fetch, load or store), the current address-space identifier and a kernel-mode flag. The block sorts the address into one of three regions. Two of them are fixed, unmapped kernel windows whose physical address is the virtual address with its top three bits cleared. The rest of the space is mapped. The block also checks alignment and privilege, and it flags accesses that must bypass the caches.

The translation buffer looks up the same request in the same cycle and presents its own fault code. The block merges that code with its own checks under a fixed priority and reports one final fault code. On every reported fault it loads a set of capture registers for the exception handler: the faulting virtual address, the split page number (upper part plus a two-bit extension), the identifier, and a second copy of the upper page-number part for the context view. These registers keep their values until the next reported fault. Each response is registered and appears exactly one clock after its request.

Top module: `vaseg_guard`

## Requirements
- R1: A request accepted with `req_valid` high produces `rsp_valid` high on the next clock edge, and there is no response in any other cycle. After reset every output is zero.
- R2: For a load (kind 1) or store (kind 2 or 3), if `vaddr AND (2^size_lg - 1)` is nonzero, the fault code is 1 (alignment). This outranks every other fault.
- R3: An address whose top three bits are 100 (the cached unmapped window, 0x80000000 to 0x9FFFFFFF) raises fault code 2 for a fetch (kind 0) or 3 for a data access when `req_kernel` is low, or when a fetch there is not 4-byte aligned. A misaligned fetch (low two address bits nonzero) in the mapped region also gives code 2.
- R4: In either unmapped window (top bits 100 or 101) with no fault, `rsp_bypass` is 1 and `rsp_paddr` is the address with bits 31:29 cleared. The translation-buffer fault code has no effect there.
- R5: In the mapped region (top bits neither 100 nor 101) `rsp_bypass` and `rsp_paddr` are 0. If no earlier check fires, a buffer fault t of 1, 2 or 3 (refill, invalid, modified) becomes final code 3+t (4, 5 or 6). Final code 0 means no fault.
- R6: `rsp_uncached` is 1 exactly when `vaddr AND 0xA0000000` equals 0xA0000000, whatever the fault outcome.
- R7: On a response with a nonzero fault code, the capture registers take: `cap_badvaddr` = vaddr, `cap_vpn2` = vaddr[31:13], `cap_vpn2_ext` = vaddr[12:11], `cap_asid` = the request identifier, `cap_ctx_vpn2` = vaddr[31:13]. They change in the same cycle that the fault code is shown.
- R8: The capture registers keep their values through fault-free responses and idle cycles.
- R9: The uncached unmapped window (top bits 101) raises no privilege fault outside kernel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_size_lg | input | 2 | Data width as log2 of bytes |
| req_kind | input | 2 | 0 fetch, 1 load, 2 and 3 store |
| req_asid | input | 8 | Address-space identifier |
| req_kernel | input | 1 | Requester runs in kernel mode |
| tb_fault | input | 2 | Buffer result: 0 none, 1 refill, 2 invalid, 3 modified |
| rsp_valid | output | 1 | Response present |
| rsp_bypass | output | 1 | Address translated by fixed stripping |
| rsp_paddr | output | 32 | Physical address when bypassing, else 0 |
| rsp_uncached | output | 1 | Access must not be cached |
| rsp_fault | output | 3 | Final fault code 0 to 6 |
| cap_badvaddr | output | 32 | Captured faulting address |
| cap_vpn2 | output | 19 | Captured upper page number |
| cap_vpn2_ext | output | 2 | Captured page-number extension bits |
| cap_asid | output | 8 | Captured identifier |
| cap_ctx_vpn2 | output | 19 | Captured upper page number, context view |

## Verification
A wrong priority decision or a wrong region decode shows on `rsp_fault`, `rsp_bypass` or `rsp_paddr` in the very response of the request that triggered it, one clock after the request. A capture register loaded at the wrong moment, or not loaded, shows on the capture outputs in that same cycle, or in the next idle or fault-free cycle when the registers should have kept their values. The stimulus puts competing faults together (misaligned data in the privileged window, buffer faults on bypassed and misaligned addresses), so that an ordering slip changes a visible code.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_ALIGN       = 3'd1,
    FLT_ADDR_FETCH  = 3'd2,
    FLT_ADDR_DATA   = 3'd3,
    FLT_TB_REFILL   = 3'd4,
    FLT_TB_INVALID  = 3'd5,
    FLT_TB_MODIFIED = 3'd6
  } fault_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_STX   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    SEG_MAPPED   = 2'd0,
    SEG_UNMAP_C  = 2'd1,
    SEG_UNMAP_U  = 2'd2
  } seg_e;

endpackage

// File: rtl/vaseg_decode.sv
module vaseg_decode
  import vaseg_pkg::*;
#(
  parameter int                VA_W      = 32,
  parameter int                SEG_W     = 3,
  parameter logic [SEG_W-1:0]  CSEG_TAG  = 3'b100,
  parameter logic [SEG_W-1:0]  USEG_TAG  = 3'b101,
  parameter logic [VA_W-1:0]   UC_MASK   = 32'hA000_0000
) (
  input  logic [VA_W-1:0] va,
  output seg_e            seg,
  output logic [VA_W-1:0] strip_pa,
  output logic            uncached
);
  localparam int OFF_W = VA_W - SEG_W;

  logic [SEG_W-1:0] top;

  always_comb begin
    top = va[VA_W-1 -: SEG_W];
    if (top == CSEG_TAG)      seg = SEG_UNMAP_C;
    else if (top == USEG_TAG) seg = SEG_UNMAP_U;
    else                      seg = SEG_MAPPED;
  end

  assign strip_pa = {{SEG_W{1'b0}}, va[OFF_W-1:0]};
  assign uncached = ((va & UC_MASK) == UC_MASK);

endmodule

// File: rtl/vaseg_check.sv
module vaseg_check
  import vaseg_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int SIZE_W   = 2,
  parameter int FETCH_LG = 2
) (
  input  logic [VA_W-1:0]   va,
  input  logic [SIZE_W-1:0] size_lg,
  input  logic [1:0]        kind,
  input  logic              kernel,
  input  seg_e              seg,
  input  logic [1:0]        tb_fault,
  output fault_e            fault,
  output logic              bypass
);
  localparam int MAX_LG = (1 << SIZE_W) - 1;
  localparam int CHK_W  = (MAX_LG > FETCH_LG) ? MAX_LG : FETCH_LG;

  logic [CHK_W-1:0] size_mask;
  logic [CHK_W-1:0] fetch_mask;
  logic             is_fetch;
  logic             data_mis;
  logic             fetch_mis;
  logic             unmapped;

  genvar gi;
  generate
    for (gi = 0; gi < CHK_W; gi++) begin : g_mask
      assign size_mask[gi]  = (gi < int'(size_lg));
      assign fetch_mask[gi] = (gi < FETCH_LG);
    end
  endgenerate

  assign is_fetch  = (kind == ACC_FETCH);
  assign data_mis  = !is_fetch && ((va[CHK_W-1:0] & size_mask) != '0);
  assign fetch_mis = is_fetch && ((va[CHK_W-1:0] & fetch_mask) != '0);
  assign unmapped  = (seg != SEG_MAPPED);

  always_comb begin
    fault = FLT_NONE;
    if (data_mis) begin
      fault = FLT_ALIGN;
    end else if (seg == SEG_UNMAP_C && (!kernel || fetch_mis)) begin
      fault = is_fetch ? FLT_ADDR_FETCH : FLT_ADDR_DATA;
    end else if (seg == SEG_MAPPED && fetch_mis) begin
      fault = FLT_ADDR_FETCH;
    end else if (seg == SEG_MAPPED && tb_fault != 2'd0) begin
      fault = fault_e'(3'(FLT_ADDR_DATA) + {1'b0, tb_fault});
    end
  end

  assign bypass = unmapped && (fault == FLT_NONE);

endmodule

// File: rtl/vaseg_capture.sv
module vaseg_capture #(
  parameter int VA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int VPN_LSB = 11,
  parameter int EXT_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [VA_W-1:0]              va,
  input  logic [ASID_W-1:0]            asid,
  output logic [VA_W-1:0]              badvaddr,
  output logic [VA_W-VPN_LSB-EXT_W-1:0] vpn2,
  output logic [EXT_W-1:0]             vpn2_ext,
  output logic [ASID_W-1:0]            cap_asid,
  output logic [VA_W-VPN_LSB-EXT_W-1:0] ctx_vpn2
);
  localparam int VPN_W  = VA_W - VPN_LSB;
  localparam int VPN2_W = VPN_W - EXT_W;

  logic [VPN_W-1:0] vpn;
  assign vpn = va[VA_W-1:VPN_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      badvaddr <= '0;
      vpn2     <= '0;
      vpn2_ext <= '0;
      cap_asid <= '0;
      ctx_vpn2 <= '0;
    end else if (load) begin
      badvaddr <= va;
      vpn2     <= vpn[VPN_W-1:EXT_W];
      vpn2_ext <= vpn[EXT_W-1:0];
      cap_asid <= asid;
      ctx_vpn2 <= VPN2_W'(vpn >> EXT_W);
    end
  end

endmodule

// File: rtl/vaseg_guard.sv
module vaseg_guard
  import vaseg_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int ASID_W   = 8,
  parameter int SIZE_W   = 2,
  parameter int FETCH_LG = 2,
  parameter int VPN_LSB  = 11,
  parameter int EXT_W    = 2,
  parameter int SEG_W    = 3,
  parameter logic [SEG_W-1:0] CSEG_TAG = 3'b100,
  parameter logic [SEG_W-1:0] USEG_TAG = 3'b101,
  parameter logic [VA_W-1:0]  UC_MASK  = 32'hA000_0000,
  localparam int VPN2_W = VA_W - VPN_LSB - EXT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [SIZE_W-1:0] req_size_lg,
  input  logic [1:0]        req_kind,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_kernel,
  input  logic [1:0]        tb_fault,
  output logic              rsp_valid,
  output logic              rsp_bypass,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              rsp_uncached,
  output logic [2:0]        rsp_fault,
  output logic [VA_W-1:0]   cap_badvaddr,
  output logic [VPN2_W-1:0] cap_vpn2,
  output logic [EXT_W-1:0]  cap_vpn2_ext,
  output logic [ASID_W-1:0] cap_asid,
  output logic [VPN2_W-1:0] cap_ctx_vpn2
);
  seg_e            seg;
  logic [VA_W-1:0] strip_pa;
  logic            uncached;
  fault_e          fault;
  logic            bypass;
  logic            cap_load;

  vaseg_decode #(
    .VA_W(VA_W), .SEG_W(SEG_W), .CSEG_TAG(CSEG_TAG),
    .USEG_TAG(USEG_TAG), .UC_MASK(UC_MASK)
  ) u_decode (
    .va(req_vaddr), .seg(seg), .strip_pa(strip_pa), .uncached(uncached)
  );

  vaseg_check #(
    .VA_W(VA_W), .SIZE_W(SIZE_W), .FETCH_LG(FETCH_LG)
  ) u_check (
    .va(req_vaddr), .size_lg(req_size_lg), .kind(req_kind),
    .kernel(req_kernel), .seg(seg), .tb_fault(tb_fault),
    .fault(fault), .bypass(bypass)
  );

  assign cap_load = req_valid && (fault != FLT_NONE);

  vaseg_capture #(
    .VA_W(VA_W), .ASID_W(ASID_W), .VPN_LSB(VPN_LSB), .EXT_W(EXT_W)
  ) u_capture (
    .clk(clk), .rst(rst), .load(cap_load), .va(req_vaddr), .asid(req_asid),
    .badvaddr(cap_badvaddr), .vpn2(cap_vpn2), .vpn2_ext(cap_vpn2_ext),
    .cap_asid(cap_asid), .ctx_vpn2(cap_ctx_vpn2)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid    <= 1'b0;
      rsp_bypass   <= 1'b0;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= 3'd0;
    end else begin
      rsp_valid    <= 1'b1;
      rsp_bypass   <= bypass;
      rsp_paddr    <= bypass ? strip_pa : '0;
      rsp_uncached <= uncached;
      rsp_fault    <= fault;
    end
  end

endmodule

// File: rtl/vaseg_guard_props.sv
module vaseg_guard_props #(
  parameter int VA_W   = 32,
  parameter int ASID_W = 8,
  parameter int EXT_W  = 2,
  parameter int VPN2_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_bypass,
  input logic [VA_W-1:0]   rsp_paddr,
  input logic [2:0]        rsp_fault,
  input logic [VA_W-1:0]   cap_badvaddr,
  input logic [VPN2_W-1:0] cap_vpn2,
  input logic [EXT_W-1:0]  cap_vpn2_ext,
  input logic [ASID_W-1:0] cap_asid,
  input logic [VPN2_W-1:0] cap_ctx_vpn2
);
  logic faulting;
  assign faulting = rsp_valid && (rsp_fault != 3'd0);

  assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_stray_resp_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_bypass_clean_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_bypass |-> (rsp_valid && rsp_fault == 3'd0 && rsp_paddr[VA_W-1 -: 3] == 3'd0));
  assert_mapped_pa_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !rsp_bypass |-> rsp_paddr == '0);
  assert_code_legal_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_fault != 3'd7);
  assert_cap_split_R7: assert property (@(posedge clk) disable iff (rst)
    faulting |-> (cap_vpn2 == cap_badvaddr[VA_W-1 -: VPN2_W]
                  && cap_vpn2_ext == cap_badvaddr[VA_W-VPN2_W-1 -: EXT_W]));
  assert_ctx_match_R7: assert property (@(posedge clk) disable iff (rst)
    cap_ctx_vpn2 == cap_vpn2);
  assert_cap_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !faulting |-> ($stable(cap_badvaddr) && $stable(cap_vpn2) && $stable(cap_vpn2_ext)
                   && $stable(cap_asid) && $stable(cap_ctx_vpn2)));

endmodule

bind vaseg_guard vaseg_guard_props #(
  .VA_W(VA_W), .ASID_W(ASID_W), .EXT_W(EXT_W), .VPN2_W(VPN2_W)
) u_props (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_bypass(rsp_bypass), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .cap_badvaddr(cap_badvaddr), .cap_vpn2(cap_vpn2), .cap_vpn2_ext(cap_vpn2_ext),
  .cap_asid(cap_asid), .cap_ctx_vpn2(cap_ctx_vpn2)
);

// File: tb/vaseg_guard_bench.sv
`timescale 1ns/1ps
module vaseg_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_size_lg = '0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_asid = '0;
  logic        req_kernel = 1'b0;
  logic [1:0]  tb_fault = '0;
  logic        rsp_valid, rsp_bypass, rsp_uncached;
  logic [31:0] rsp_paddr, cap_badvaddr;
  logic [2:0]  rsp_fault;
  logic [18:0] cap_vpn2, cap_ctx_vpn2;
  logic [1:0]  cap_vpn2_ext;
  logic [7:0]  cap_asid;

  always #2 clk = ~clk;

  vaseg_guard u_vaseg_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_size_lg(req_size_lg), .req_kind(req_kind), .req_asid(req_asid),
    .req_kernel(req_kernel), .tb_fault(tb_fault), .rsp_valid(rsp_valid),
    .rsp_bypass(rsp_bypass), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
    .rsp_fault(rsp_fault), .cap_badvaddr(cap_badvaddr), .cap_vpn2(cap_vpn2),
    .cap_vpn2_ext(cap_vpn2_ext), .cap_asid(cap_asid), .cap_ctx_vpn2(cap_ctx_vpn2)
  );

  typedef struct {
    logic [36:0] rsp;
    logic [79:0] cap;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [79:0] model_cap = '0;
  logic [79:0] last_cap  = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_fault(logic [31:0] va, logic [1:0] lg,
      logic [1:0] kind, logic kern, logic [1:0] tbf);
    logic [31:0] m;
    bit mis, k0, k1;
    m   = (32'd1 << ((kind == 2'd0) ? 2 : lg)) - 32'd1;
    mis = (va & m) != 0;
    k0  = va[31:29] == 3'b100;
    k1  = va[31:29] == 3'b101;
    if (kind != 2'd0 && mis) return 3'd1;
    if (k0 && (!kern || mis)) return (kind == 2'd0) ? 3'd2 : 3'd3;
    if (!k0 && !k1 && mis) return 3'd2;
    if (!k0 && !k1 && tbf != 2'd0) return 3'd3 + {1'b0, tbf};
    return 3'd0;
  endfunction

  task automatic send(input logic [31:0] va, input logic [1:0] lg, input logic [1:0] kind,
                      input logic [7:0] asid, input logic kern, input logic [1:0] tbf,
                      input string tag);
    item_t it;
    logic [2:0] f;
    logic byp, uc;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_size_lg = lg; req_kind = kind;
    req_asid = asid; req_kernel = kern; tb_fault = tbf;
    f   = exp_fault(va, lg, kind, kern, tbf);
    byp = (va[31:29] == 3'b100 || va[31:29] == 3'b101) && f == 3'd0;
    uc  = (va & 32'hA000_0000) == 32'hA000_0000;
    if (f != 3'd0) model_cap = {va, va[31:13], va[12:11], asid, va[31:13]};
    it.rsp = {f, byp, byp ? {3'b000, va[28:0]} : 32'd0, uc};
    it.cap = model_cap;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; tb_fault = 2'd3;
    end
  endtask

  always begin
    @(posedge clk);
    #1;
    if (!rst) begin
      logic [36:0] ar;
      logic [79:0] ac;
      item_t e;
      ar = {rsp_fault, rsp_bypass, rsp_paddr, rsp_uncached};
      ac = {cap_badvaddr, cap_vpn2, cap_vpn2_ext, cap_asid, cap_ctx_vpn2};
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(0, "R1 unexpected response", 128'(ar), 128'(0));
        end else begin
          e = sb.pop_front();
          check(ar == e.rsp, e.tag, 128'(ar), 128'(e.rsp));
          check(ac == e.cap, {e.tag, " R7 capture"}, 128'(ac), 128'(e.cap));
          last_cap = e.cap;
        end
      end else if (sb.size() != 0 || n_chk > 0) begin
        check(sb.size() == 0, "R1 missing response", 128'(sb.size()), 128'(0));
        check(ac == last_cap, "R8 capture held while idle", 128'(ac), 128'(last_cap));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=%0d exp=0", sb.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check({rsp_valid, rsp_bypass, rsp_paddr, rsp_uncached, rsp_fault} == '0,
          "R1 reset outputs", 128'(rsp_paddr), 128'(0));
    check({cap_badvaddr, cap_vpn2, cap_vpn2_ext, cap_asid, cap_ctx_vpn2} == '0,
          "R8 reset capture", 128'(cap_badvaddr), 128'(0));
    send(32'h0040_1000, 2'd2, 2'd1, 8'h11, 1'b0, 2'd0, "R5 mapped clean load");
    send(32'h0040_1002, 2'd2, 2'd1, 8'h12, 1'b0, 2'd0, "R2 misaligned word load");
    send(32'h8000_1234, 2'd1, 2'd2, 8'h13, 1'b1, 2'd0, "R4 cached window kernel store");
    idle(2);
    send(32'h8000_1234, 2'd1, 2'd2, 8'h14, 1'b0, 2'd0, "R3 cached window user store");
    send(32'h8000_0010, 2'd0, 2'd0, 8'h15, 1'b0, 2'd0, "R3 cached window user fetch");
    send(32'h8000_0812, 2'd0, 2'd0, 8'h16, 1'b1, 2'd0, "R3 cached window misaligned fetch");
    send(32'h8000_0002, 2'd2, 2'd1, 8'h17, 1'b0, 2'd0, "R2 alignment beats privilege");
    send(32'hA000_0040, 2'd3, 2'd1, 8'h18, 1'b0, 2'd0, "R9 R6 uncached window user load");
    send(32'hBFFF_F800, 2'd2, 2'd2, 8'h19, 1'b1, 2'd1, "R4 buffer fault ignored in window");
    send(32'hC000_3800, 2'd2, 2'd1, 8'h1A, 1'b1, 2'd1, "R5 refill code");
    idle(1);
    send(32'h7FFF_E800, 2'd0, 2'd0, 8'h1B, 1'b0, 2'd2, "R5 invalid code");
    send(32'hE000_5800, 2'd1, 2'd2, 8'h1C, 1'b1, 2'd3, "R5 R6 modified code uncached");
    send(32'h0000_6806, 2'd3, 2'd1, 8'h1D, 1'b0, 2'd1, "R2 alignment beats buffer");
    send(32'h0000_7002, 2'd0, 2'd0, 8'h1E, 1'b0, 2'd1, "R3 misaligned mapped fetch");
    send(32'h1234_5678, 2'd0, 2'd1, 8'h1F, 1'b0, 2'd0, "R8 clean byte load keeps capture");
    send(32'hF000_0000, 2'd2, 2'd0, 8'h20, 1'b1, 2'd0, "R6 mapped top uncached fetch");
    send(32'h9FFF_FFFC, 2'd2, 2'd1, 8'h21, 1'b1, 2'd2, "R4 window top edge");
    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule